// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block keeps the interrupt state of a single processor and decides, one cycle at a time, whether an interrupt offered by the source controller should be signalled to that processor. It holds a 32-bit presentation word, a pending-priority byte and an inter-processor request (IPI) priority byte, and it drives one interrupt line. The processor side works through a command port: it takes the pending interrupt, reads the state, sets its current priority level, sets the IPI priority, or signals end of service. The source side offers interrupts and receives notifications: a refusal for an offer that loses, a displacement notice for a source that was pending and had to give way, an end-of-service notice, and a resend request when the processor becomes able to take more work.

A single pending slot is shared by external sources and the software IPI. The slot is modelled as a three-state machine: `SLOT_EMPTY` (nothing pending), `SLOT_EXT` (a source from the source controller is pending) and `SLOT_IPI` (the fixed IPI source number is pending). The transitions are: *take* (any state to `SLOT_EXT`, an offer wins), *ipi_present* (`SLOT_EMPTY` or `SLOT_EXT` to `SLOT_IPI`, or `SLOT_IPI` to itself with a better priority), *accept* (any state to `SLOT_EMPTY`, processor takes the interrupt) and *revoke* (`SLOT_EXT` or `SLOT_IPI` to `SLOT_EMPTY`, the current priority drops to or below the pending one). Only a source in `SLOT_EXT` is ever handed back through the displacement notice; an IPI that loses its slot just disappears.

Priorities are 8-bit values where a smaller number is more favoured and 0xFF means "none". All commands and offers take effect at one clock edge; responses and notifications appear as one-cycle strobes registered at that same edge.

Top module: `cpu_intr_presenter`

## Requirements
- R1: After reset the presentation word reads 0x00000000, the pending priority and the IPI priority are 0xFF, the interrupt line is low and no strobe is active.
- R2: The presentation word holds the current priority in bits 31:24 and the pending source number in bits 23:0; command codes are 1 take, 2 poll, 3 set current priority (data bits 7:0), 4 set IPI priority (data bits 7:0), 5 end of service (data is a full word); every response or notification is a strobe lasting exactly one cycle, present in the cycle after the command.
- R3: An offer is refused, with a refusal strobe carrying its source number and no change of state, when its priority is greater than or equal to the current priority or when a pending source has a priority less than or equal to the offered one.
- R4: An offer that wins loads its source number and priority and raises the line; if an external source was pending it is reported on the displacement strobe, while a pending IPI is overwritten without any notice.
- R5: The take command returns the presentation word as it stood, loads the current priority with the old pending priority, clears the source field, sets the pending priority to 0xFF and lowers the line.
- R6: Setting a current priority numerically below the old one and less than or equal to the pending priority revokes the pending entry: the source field clears, the pending priority becomes 0xFF, the line drops and an external source is reported as displaced; a new value above the pending priority leaves the pending entry in place.
- R7: Setting a current priority greater than or equal to the old one while nothing is pending raises the resend strobe, and presents the IPI in the same step if the IPI priority is below the new current priority.
- R8: Setting the IPI priority below the current priority presents the IPI (source number parameter, default 2) with that priority and raises the line, displacing any pending external source, unless the pending priority is already less than or equal to the new IPI priority.
- R9: End of service loads the current priority from data bits 31:24, strobes data bits 23:0 as the end-of-service source number, and, if nothing is pending, raises the resend strobe and presents the IPI when its priority is below the new current priority.
- R10: The poll command returns the presentation word and the IPI priority and changes no state.
- R11: When an offer and a command arrive in the same cycle, the command takes effect and the offer is refused with a refusal strobe carrying its source number.
- R12: An offer with source number zero is dropped with no strobe and no change of state; a command with code 0, 6 or 7 has no effect.
- R13: The interrupt line is high exactly when the source field of the presentation word is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| rsp_valid | output | 1 | Response strobe for take and poll |
| rsp_word | output | 32 | Presentation word returned |
| rsp_ipi | output | 8 | IPI priority returned |
| rej_valid | output | 1 | Displaced pending source strobe |
| rej_src | output | 24 | Displaced source number |
| ref_valid | output | 1 | Refused offer strobe |
| ref_src | output | 24 | Refused source number |
| eoi_valid | output | 1 | End-of-service notification strobe |
| eoi_src | output | 24 | Source number that finished service |
| resend_req | output | 1 | Request to the source controller to offer again |

## Verification
Two functions can land on the same edge: a processor command and an offer from the source controller, and further an end-of-service or priority write whose resend path presents the IPI in the very cycle it raises the resend strobe. The first is provoked by holding an offer on the port during a poll and judged by seeing the poll response together with a refusal strobe for that offer and no change to the word; the second is provoked by ending service with a favourable IPI priority in place and judged by seeing the resend strobe, the end-of-service strobe, the raised line and the IPI source number in the following poll.

// File: rtl/intr_presenter_pkg.sv
package intr_presenter_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_TAKE      = 3'd1,
        OP_POLL      = 3'd2,
        OP_SET_LEVEL = 3'd3,
        OP_SET_IPI   = 3'd4,
        OP_DONE      = 3'd5,
        OP_RSV6      = 3'd6,
        OP_RSV7      = 3'd7
    } cmd_op_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_EXT   = 2'd1,
        SLOT_IPI   = 2'd2
    } slot_e;

endpackage

// File: rtl/cip_prio_judge.sv
// Decides whether a candidate priority beats both the current level and
// whatever already occupies the pending slot.
module cip_prio_judge #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] level_prio,
    input  logic [PRIO_W-1:0] held_prio,
    input  logic              slot_busy,
    output logic              wins
);
    logic beats_level;
    logic beats_held;

    always_comb begin
        beats_level = (cand_prio < level_prio);
        beats_held  = !slot_busy || (cand_prio < held_prio);
        wins        = beats_level && beats_held;
    end
endmodule

// File: rtl/cip_out_stage.sv
// Registers every output of the presenter; strobes are one cycle wide.
module cip_out_stage #(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     n_irq,
    input  logic                     n_rsp_v,
    input  logic [PRIO_W+SRC_W-1:0]  n_rsp_word,
    input  logic [PRIO_W-1:0]        n_rsp_ipi,
    input  logic                     n_rej_v,
    input  logic [SRC_W-1:0]         n_rej_src,
    input  logic                     n_ref_v,
    input  logic [SRC_W-1:0]         n_ref_src,
    input  logic                     n_eoi_v,
    input  logic [SRC_W-1:0]         n_eoi_src,
    input  logic                     n_resend,
    output logic                     irq_out,
    output logic                     rsp_valid,
    output logic [PRIO_W+SRC_W-1:0]  rsp_word,
    output logic [PRIO_W-1:0]        rsp_ipi,
    output logic                     rej_valid,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     ref_valid,
    output logic [SRC_W-1:0]         ref_src,
    output logic                     eoi_valid,
    output logic [SRC_W-1:0]         eoi_src,
    output logic                     resend_req
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out    <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_word   <= '0;
            rsp_ipi    <= '1;
            rej_valid  <= 1'b0;
            rej_src    <= '0;
            ref_valid  <= 1'b0;
            ref_src    <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
            resend_req <= 1'b0;
        end else begin
            irq_out    <= n_irq;
            rsp_valid  <= n_rsp_v;
            rsp_word   <= n_rsp_word;
            rsp_ipi    <= n_rsp_ipi;
            rej_valid  <= n_rej_v;
            rej_src    <= n_rej_src;
            ref_valid  <= n_ref_v;
            ref_src    <= n_ref_src;
            eoi_valid  <= n_eoi_v;
            eoi_src    <= n_eoi_src;
            resend_req <= n_resend;
        end
    end
endmodule

// File: rtl/cpu_intr_presenter.sv
module cpu_intr_presenter
    import intr_presenter_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     offer_valid,
    input  logic [SRC_W-1:0]         offer_src,
    input  logic [PRIO_W-1:0]        offer_prio,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [PRIO_W+SRC_W-1:0]  cmd_data,
    output logic                     irq_out,
    output logic                     rsp_valid,
    output logic [PRIO_W+SRC_W-1:0]  rsp_word,
    output logic [PRIO_W-1:0]        rsp_ipi,
    output logic                     rej_valid,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     ref_valid,
    output logic [SRC_W-1:0]         ref_src,
    output logic                     eoi_valid,
    output logic [SRC_W-1:0]         eoi_src,
    output logic                     resend_req
);
    localparam int                WORD_W  = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] P_NONE  = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

    // State register contents
    slot_e             slot_q,  slot_n;
    logic [PRIO_W-1:0] level_q, level_n;
    logic [SRC_W-1:0]  src_q,   src_n;
    logic [PRIO_W-1:0] pend_q,  pend_n;
    logic [PRIO_W-1:0] ipi_q,   ipi_n;

    // Next output values
    logic              o_irq, o_rsp_v, o_rej_v, o_ref_v, o_eoi_v, o_resend;
    logic [WORD_W-1:0] o_rsp_word;
    logic [SRC_W-1:0]  o_rej_src, o_ref_src, o_eoi_src;

    cmd_op_e           op;
    logic [PRIO_W-1:0] arg_lo;
    logic [PRIO_W-1:0] arg_hi;
    logic              slot_busy;
    logic              offer_wins;
    logic              ipi_wins;
    logic [PRIO_W-1:0] ipi_cand;
    logic [PRIO_W-1:0] ipi_level;
    logic              present_ipi;

    always_comb begin
        op        = cmd_op_e'(cmd_op);
        arg_lo    = cmd_data[PRIO_W-1:0];
        arg_hi    = cmd_data[WORD_W-1:SRC_W];
        slot_busy = (slot_q != SLOT_EMPTY);
    end

    // IPI candidate and the level it must beat depend on the command.
    always_comb begin
        ipi_cand  = ipi_q;
        ipi_level = level_q;
        unique case (op)
            OP_SET_IPI:   ipi_cand  = arg_lo;
            OP_SET_LEVEL: ipi_level = arg_lo;
            OP_DONE:      ipi_level = arg_hi;
            default:      ;
        endcase
    end

    cip_prio_judge #(.PRIO_W(PRIO_W)) u_offer_judge (
        .cand_prio (offer_prio),
        .level_prio(level_q),
        .held_prio (pend_q),
        .slot_busy (slot_busy),
        .wins      (offer_wins)
    );

    cip_prio_judge #(.PRIO_W(PRIO_W)) u_ipi_judge (
        .cand_prio (ipi_cand),
        .level_prio(ipi_level),
        .held_prio (pend_q),
        .slot_busy (slot_busy),
        .wins      (ipi_wins)
    );

    // Next-state and next-output logic
    always_comb begin
        slot_n     = slot_q;
        level_n    = level_q;
        src_n      = src_q;
        pend_n     = pend_q;
        ipi_n      = ipi_q;
        o_irq      = irq_out;
        o_rsp_v    = 1'b0;
        o_rsp_word = {level_q, src_q};
        o_rej_v    = 1'b0;
        o_rej_src  = '0;
        o_ref_v    = 1'b0;
        o_ref_src  = '0;
        o_eoi_v    = 1'b0;
        o_eoi_src  = '0;
        o_resend   = 1'b0;
        present_ipi = 1'b0;

        if (cmd_valid) begin
            // A command owns the cycle; a simultaneous offer bounces.
            if (offer_valid && (offer_src != '0)) begin
                o_ref_v   = 1'b1;
                o_ref_src = offer_src;
            end
            unique case (op)
                OP_TAKE: begin
                    o_rsp_v = 1'b1;
                    level_n = pend_q;
                    src_n   = '0;
                    pend_n  = P_NONE;
                    slot_n  = SLOT_EMPTY;
                    o_irq   = 1'b0;
                end
                OP_POLL: begin
                    o_rsp_v = 1'b1;
                end
                OP_SET_LEVEL: begin
                    level_n = arg_lo;
                    if (arg_lo < level_q) begin
                        if (slot_busy && (arg_lo <= pend_q)) begin
                            if (slot_q == SLOT_EXT) begin
                                o_rej_v   = 1'b1;
                                o_rej_src = src_q;
                            end
                            src_n  = '0;
                            pend_n = P_NONE;
                            slot_n = SLOT_EMPTY;
                            o_irq  = 1'b0;
                        end
                    end else if (!slot_busy) begin
                        o_resend    = 1'b1;
                        present_ipi = ipi_wins;
                    end
                end
                OP_SET_IPI: begin
                    ipi_n       = arg_lo;
                    present_ipi = ipi_wins;
                end
                OP_DONE: begin
                    level_n   = arg_hi;
                    o_eoi_v   = 1'b1;
                    o_eoi_src = cmd_data[SRC_W-1:0];
                    if (!slot_busy) begin
                        o_resend    = 1'b1;
                        present_ipi = ipi_wins;
                    end
                end
                OP_NONE, OP_RSV6, OP_RSV7: ;
                default: ;
            endcase

            if (present_ipi) begin
                if (slot_q == SLOT_EXT) begin
                    o_rej_v   = 1'b1;
                    o_rej_src = src_q;
                end
                slot_n = SLOT_IPI;
                src_n  = IPI_NUM;
                pend_n = ipi_cand;
                o_irq  = 1'b1;
            end
        end else if (offer_valid && (offer_src != '0)) begin
            if (offer_wins) begin
                if (slot_q == SLOT_EXT) begin
                    o_rej_v   = 1'b1;
                    o_rej_src = src_q;
                end
                slot_n = SLOT_EXT;
                src_n  = offer_src;
                pend_n = offer_prio;
                o_irq  = 1'b1;
            end else begin
                o_ref_v   = 1'b1;
                o_ref_src = offer_src;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SLOT_EMPTY;
            level_q <= '0;
            src_q   <= '0;
            pend_q  <= P_NONE;
            ipi_q   <= P_NONE;
        end else begin
            slot_q  <= slot_n;
            level_q <= level_n;
            src_q   <= src_n;
            pend_q  <= pend_n;
            ipi_q   <= ipi_n;
        end
    end

    // Output registers
    cip_out_stage #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_irq     (o_irq),
        .n_rsp_v   (o_rsp_v),
        .n_rsp_word(o_rsp_word),
        .n_rsp_ipi (ipi_q),
        .n_rej_v   (o_rej_v),
        .n_rej_src (o_rej_src),
        .n_ref_v   (o_ref_v),
        .n_ref_src (o_ref_src),
        .n_eoi_v   (o_eoi_v),
        .n_eoi_src (o_eoi_src),
        .n_resend  (o_resend),
        .irq_out   (irq_out),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .rsp_ipi   (rsp_ipi),
        .rej_valid (rej_valid),
        .rej_src   (rej_src),
        .ref_valid (ref_valid),
        .ref_src   (ref_src),
        .eoi_valid (eoi_valid),
        .eoi_src   (eoi_src),
        .resend_req(resend_req)
    );

    // Assertions
    assert_line_tracks_src_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (src_q != '0));

    assert_empty_has_no_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == '0) |-> (pend_q == P_NONE));

    assert_take_empties_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_TAKE) |=> (src_q == '0 && !irq_out && pend_q == P_NONE && rsp_valid));

    assert_poll_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_POLL) |=> ($stable(src_q) && $stable(level_q) && $stable(pend_q) && $stable(ipi_q)));

    assert_cmd_bounces_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && offer_valid && offer_src != '0) |=> (ref_valid && ref_src == $past(offer_src)));

    assert_zero_src_dropped_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && offer_valid && offer_src == '0) |=> (!ref_valid && !rej_valid && $stable(src_q)));

    assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(cmd_valid)) |-> 1'b0);
endmodule

// File: tb/cpu_intr_presenter_tb.sv
module cpu_intr_presenter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        irq_out, rsp_valid, rej_valid, ref_valid, eoi_valid, resend_req;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_ipi;
    logic [23:0] rej_src, ref_src, eoi_src;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [2:0] C_TAKE = 3'd1, C_POLL = 3'd2, C_LEVEL = 3'd3,
                           C_IPI = 3'd4, C_DONE = 3'd5;

    always #10 clk = ~clk;

    cpu_intr_presenter u_dut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_out(irq_out), .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi),
        .rej_valid(rej_valid), .rej_src(rej_src), .ref_valid(ref_valid), .ref_src(ref_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs change on the falling edge; results are read on the next one.
    task automatic cmd(input logic [2:0] op, input logic [31:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
    endtask

    task automatic offer(input logic [23:0] s, input logic [7:0] p);
        offer_valid = 1'b1; offer_src = s; offer_prio = p;
        @(negedge clk);
        offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
    endtask

    task automatic poll_expect(input string tag, input logic [31:0] word, input logic [7:0] ipi);
        cmd(C_POLL, 32'h0);
        chk({tag, " word"}, rsp_word, word);
        chk({tag, " ipi"}, {24'h0, rsp_ipi}, {24'h0, ipi});
        chk({tag, " R13 line"}, {31'h0, irq_out}, {31'h0, word[23:0] != 24'h0});
    endtask

    task automatic t_reset;
        chk("R1 line low", {31'h0, irq_out}, 32'h0);
        chk("R1 strobes idle", {27'h0, rsp_valid, rej_valid, ref_valid, eoi_valid, resend_req}, 32'h0);
        poll_expect("R1 reset state", 32'h0000_0000, 8'hFF);
    endtask

    task automatic t_refuse;
        cmd(C_LEVEL, 32'h80);
        chk("R7 resend on raise", {31'h0, resend_req}, 32'h1);
        chk("R2 strobe one cycle", {31'h0, rsp_valid}, 32'h0);
        offer(24'h10, 8'h80);
        chk("R3 refused equal level", {31'h0, ref_valid}, 32'h1);
        chk("R3 refused src", {8'h0, ref_src}, 32'h10);
        chk("R3 line stays low", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_take_offer;
        offer(24'h11, 8'h40);
        chk("R4 line raised", {31'h0, irq_out}, 32'h1);
        chk("R4 no displacement", {31'h0, rej_valid}, 32'h0);
        poll_expect("R4 loaded", 32'h8000_0011, 8'hFF);
        offer(24'h12, 8'h40);
        chk("R3 refused by pending", {31'h0, ref_valid}, 32'h1);
        chk("R3 refused src", {8'h0, ref_src}, 32'h12);
        offer(24'h13, 8'h20);
        chk("R4 displaced strobe", {31'h0, rej_valid}, 32'h1);
        chk("R4 displaced src", {8'h0, rej_src}, 32'h11);
        poll_expect("R4 replaced", 32'h8000_0013, 8'hFF);
    endtask

    task automatic t_accept_eoi;
        cmd(C_TAKE, 32'h0);
        chk("R5 returned word", rsp_word, 32'h8000_0013);
        chk("R5 line low", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R2 response one cycle", {31'h0, rsp_valid}, 32'h0);
        poll_expect("R5 level from pending", 32'h2000_0000, 8'hFF);
        cmd(C_DONE, 32'h8000_0013);
        chk("R9 done strobe", {31'h0, eoi_valid}, 32'h1);
        chk("R9 done src", {8'h0, eoi_src}, 32'h13);
        chk("R9 resend", {31'h0, resend_req}, 32'h1);
        poll_expect("R9 level restored", 32'h8000_0000, 8'hFF);
    endtask

    task automatic t_revoke;
        offer(24'h21, 8'h30);
        cmd(C_LEVEL, 32'h30);
        chk("R6 revoke displaced", {31'h0, rej_valid}, 32'h1);
        chk("R6 revoke src", {8'h0, rej_src}, 32'h21);
        chk("R6 line low", {31'h0, irq_out}, 32'h0);
        chk("R6 no resend", {31'h0, resend_req}, 32'h0);
        poll_expect("R6 cleared", 32'h3000_0000, 8'hFF);
        cmd(C_LEVEL, 32'h80);
        chk("R7 resend", {31'h0, resend_req}, 32'h1);
        offer(24'h22, 8'h30);
        cmd(C_LEVEL, 32'h50);
        chk("R6 kept no displacement", {31'h0, rej_valid}, 32'h0);
        poll_expect("R6 kept", 32'h5000_0022, 8'hFF);
        cmd(C_TAKE, 32'h0);
        cmd(C_DONE, 32'h8000_0022);
    endtask

    task automatic t_ipi;
        offer(24'h23, 8'h60);
        cmd(C_IPI, 32'h70);
        chk("R8 no ipi when pending better", {31'h0, rej_valid}, 32'h0);
        poll_expect("R8 pending kept", 32'h8000_0023, 8'h70);
        cmd(C_IPI, 32'h50);
        chk("R8 ipi displaces external", {31'h0, rej_valid}, 32'h1);
        chk("R8 displaced src", {8'h0, rej_src}, 32'h23);
        poll_expect("R8 ipi pending", 32'h8000_0002, 8'h50);
        offer(24'h24, 8'h10);
        chk("R4 ipi overwritten silently", {31'h0, rej_valid}, 32'h0);
        poll_expect("R4 over ipi", 32'h8000_0024, 8'h50);
        cmd(C_TAKE, 32'h0);
        chk("R5 returned word", rsp_word, 32'h8000_0024);
        cmd(C_DONE, 32'h8000_0024);
        chk("R9 resend with ipi", {31'h0, resend_req}, 32'h1);
        chk("R9 ipi raises line", {31'h0, irq_out}, 32'h1);
        poll_expect("R9 ipi presented", 32'h8000_0002, 8'h50);
        cmd(C_TAKE, 32'h0);
        poll_expect("R5 ipi taken", 32'h5000_0000, 8'h50);
        cmd(C_IPI, 32'hFF);
        cmd(C_DONE, 32'h8000_0002);
        chk("R9 done ipi src", {8'h0, eoi_src}, 32'h2);
        poll_expect("R9 no ipi", 32'h8000_0000, 8'hFF);
    endtask

    task automatic t_same_cycle;
        offer_valid = 1'b1; offer_src = 24'h31; offer_prio = 8'h10;
        cmd(C_POLL, 32'h0);
        offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
        chk("R11 poll answered", {31'h0, rsp_valid}, 32'h1);
        chk("R11 poll word", rsp_word, 32'h8000_0000);
        chk("R11 offer refused", {31'h0, ref_valid}, 32'h1);
        chk("R11 refused src", {8'h0, ref_src}, 32'h31);
        chk("R11 line low", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_ignored;
        offer(24'h0, 8'h10);
        chk("R12 zero src no strobe", {30'h0, ref_valid, rej_valid}, 32'h0);
        chk("R12 zero src line", {31'h0, irq_out}, 32'h0);
        cmd(3'd7, 32'h0000_0000);
        chk("R12 reserved op silent", {27'h0, rsp_valid, rej_valid, ref_valid, eoi_valid, resend_req}, 32'h0);
        cmd(3'd0, 32'h1234_5678);
        poll_expect("R12 state unchanged", 32'h8000_0000, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refuse();
        t_take_offer();
        t_accept_eoi();
        t_revoke();
        t_ipi();
        t_same_cycle();
        t_ignored();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule